// File: doc/BRIEF.md
# Serial Pattern Unlock Controller

This block sits beside a byte-wide memory and watches the cycles that reach it. Each bus cycle arrives as a single-clock event. The event carries a direction flag and the level of data line 0. While the block is locked, every cycle goes to memory as usual. In the background, the block compares the bits written on data line 0 against a fixed 64-bit key. A read cycle re-arms that comparison. Once the whole key has matched, the block opens a window of 64 serial cycles. During the window, memory access is held off and each cycle moves one bit of a 64-bit timekeeping image.

In the window, read cycles present bits from a snapshot of the current clock registers. The snapshot is taken at the moment of unlock. Write cycles shift new bits into a capture buffer. The captured image is handed to the clock registers only after a window made entirely of writes. An active-low abort input can end a transfer early. A control bit inside the clock image decides whether that input is honoured or ignored.

Top module: `serial_unlock_ctrl`

## Requirements
- R1: After reset, `memInhibit` and `commitStrobe` are 0, and the key comparison is armed at key bit 0.
- R2: The key is 64'h5CA33AC55CA33AC5. Bit k is sent on `dqIn` in the k-th write cycle, starting with bit 0. A cycle is a write when `cycValid`=1 and `cycWrite`=1. After the 64th matching write, `memInhibit` is 1 from the next clock.
- R3: A write whose bit differs from the key bit at the pointer freezes the pointer. All later writes are then ignored for matching, so sending the remaining correct bits does not unlock.
- R4: A read cycle (`cycValid`=1, `cycWrite`=0) outside the window returns the pointer to key bit 0 and clears any mismatch, so a full key sent next unlocks.
- R5: `memInhibit` stays 0 throughout recognition, including the 64 key writes themselves.
- R6: The window lasts exactly 64 valid cycles. `memInhibit` is still 1 after 63 of them and 0 from the clock after the 64th.
- R7: The window snapshots `rtcImage` on the clock of the 64th key write. Before the k-th read of the window, `dqOut` shows snapshot bit k (register k/8, bit k%8). Changes to `rtcImage` after unlock are not seen.
- R8: When all 64 window cycles are writes, `commitStrobe` pulses for exactly one clock after the 64th write. During that pulse, `commitImage` bit k equals the bit written in the k-th window cycle.
- R9: A window that contains any read cycle ends without a commit.
- R10: When `rtcImage[36]` (bit 4 of register 4) is 0, a low `xferRstN` during the window ends it on the next clock. `memInhibit` drops and no commit occurs.
- R11: When `rtcImage[36]` is 1, `xferRstN` is ignored and the window runs to its full 64 cycles.
- R12: Clocks with `cycValid`=0 change neither the key pointer nor the window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low system reset |
| cycValid | input | 1 | One-clock strobe marking a bus cycle |
| cycWrite | input | 1 | Cycle direction: 1 write, 0 read |
| dqIn | input | 1 | Level of data line 0 on a write |
| xferRstN | input | 1 | Active-low transfer abort request |
| rtcImage | input | 64 | Current clock register values, register 0 in bits 7:0 |
| memInhibit | output | 1 | High while cycles are diverted from memory |
| dqOut | output | 1 | Serial bit to present on a window read |
| commitStrobe | output | 1 | One-clock pulse: load `commitImage` into the clock registers |
| commitImage | output | 64 | Image captured from a full write window |

## Verification
The assertions check three things on every clock. A read re-arms the pointer. A frozen comparison stays frozen under further writes. An abort leaves the block idle without a commit. They also confirm that the buffer takes the snapshot on unlock and captures each written bit at the top. The bench scenarios show what only whole sequences reveal. It places a single wrong key bit at every one of the 64 positions and confirms that no unlock follows. It checks the exact length of the window, bit-order agreement between what was written and what was committed, and that a snapshot does not follow later image changes. Finally, it checks that the abort input is honoured or ignored according to the control bit.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int KEY_W = 64;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

  typedef enum logic { ST_IDLE, ST_XFER } ctrlState_t;

  typedef struct packed {
    logic load;     // take snapshot of clock image
    logic shiftRd;  // rotate out one bit
    logic shiftWr;  // shift in one written bit
  } dpCtl_t;
endpackage

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import unlock_pkg::*;
#(
  parameter int IMG_W = 64
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   cycValid,
  input  logic   cycWrite,
  input  logic   dqIn,
  input  logic   xferRstN,
  input  logic   rstIgnore,
  output logic   memInhibit,
  output logic   commitStrobe,
  output dpCtl_t dpCtl
);
  localparam int PTR_W = $clog2(KEY_W);
  localparam int CNT_W = $clog2(IMG_W);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(KEY_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IMG_W - 1);

  ctrlState_t state;
  logic [PTR_W-1:0] ptr;
  logic blocked;
  logic [CNT_W-1:0] cnt;
  logic allWr;
  logic commitQ;

  logic isIdle, isXfer, rdCyc, wrCyc, keyHit, abort;

  always_comb begin
    isIdle = (state == ST_IDLE);
    isXfer = (state == ST_XFER);
    rdCyc  = cycValid && !cycWrite;
    wrCyc  = cycValid && cycWrite;
    keyHit = (dqIn == UNLOCK_KEY[ptr]);
    abort  = isXfer && !xferRstN && !rstIgnore;
    dpCtl.load    = isIdle && wrCyc && !blocked && keyHit && (ptr == PTR_LAST);
    dpCtl.shiftRd = isXfer && !abort && rdCyc;
    dpCtl.shiftWr = isXfer && !abort && wrCyc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ptr     <= '0;
      blocked <= 1'b0;
      cnt     <= '0;
      allWr   <= 1'b0;
      commitQ <= 1'b0;
    end else begin
      commitQ <= 1'b0;
      if (isIdle) begin
        if (rdCyc) begin
          ptr     <= '0;
          blocked <= 1'b0;
        end else if (wrCyc && !blocked) begin
          if (!keyHit) begin
            blocked <= 1'b1;
          end else if (ptr == PTR_LAST) begin
            state <= ST_XFER;
            ptr   <= '0;
            cnt   <= '0;
            allWr <= 1'b1;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
      end else if (abort) begin
        state <= ST_IDLE;
      end else if (cycValid) begin
        cnt   <= cnt + 1'b1;
        allWr <= allWr && cycWrite;
        if (cnt == CNT_LAST) begin
          state   <= ST_IDLE;
          commitQ <= allWr && cycWrite;
        end
      end
    end
  end

  assign memInhibit   = isXfer;
  assign commitStrobe = commitQ;

  AST_READ_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && rdCyc) |=> (ptr == '0 && !blocked)); // R4
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && blocked && wrCyc) |=> (blocked && $stable(ptr) && !memInhibit)); // R3
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!memInhibit && !commitStrobe)); // R10
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (!cycValid && xferRstN) |=> ($stable(ptr) && $stable(cnt) && $stable(state))); // R12
endmodule

// File: rtl/unlock_datapath.sv
module unlock_datapath
  import unlock_pkg::*;
#(
  parameter int IMG_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic             dqIn,
  input  logic [IMG_W-1:0] rtcImage,
  output logic             dqOut,
  output logic [IMG_W-1:0] bufImage
);
  logic [IMG_W-1:0] shiftBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftBuf <= '0;
    end else if (dpCtl.load) begin
      shiftBuf <= rtcImage;
    end else if (dpCtl.shiftRd) begin
      shiftBuf <= {shiftBuf[0], shiftBuf[IMG_W-1:1]};
    end else if (dpCtl.shiftWr) begin
      shiftBuf <= {dqIn, shiftBuf[IMG_W-1:1]};
    end
  end

  assign dqOut    = shiftBuf[0];
  assign bufImage = shiftBuf;

  AST_LOAD_SNAPSHOT: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.load |=> (shiftBuf == $past(rtcImage))); // R7
  AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.shiftWr |=> (shiftBuf[IMG_W-1] == $past(dqIn))); // R8
endmodule

// File: rtl/serial_unlock_ctrl.sv
module serial_unlock_ctrl
  import unlock_pkg::*;
#(
  parameter int IMG_W       = 64,
  parameter int RST_DIS_BIT = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycValid,
  input  logic             cycWrite,
  input  logic             dqIn,
  input  logic             xferRstN,
  input  logic [IMG_W-1:0] rtcImage,
  output logic             memInhibit,
  output logic             dqOut,
  output logic             commitStrobe,
  output logic [IMG_W-1:0] commitImage
);
  dpCtl_t dpCtl;
  logic rstIgnore;

  assign rstIgnore = rtcImage[RST_DIS_BIT];

  unlock_ctrl #(.IMG_W(IMG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycWrite(cycWrite),
    .dqIn(dqIn), .xferRstN(xferRstN), .rstIgnore(rstIgnore),
    .memInhibit(memInhibit), .commitStrobe(commitStrobe), .dpCtl(dpCtl)
  );

  unlock_datapath #(.IMG_W(IMG_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .dqIn(dqIn),
    .rtcImage(rtcImage), .dqOut(dqOut), .bufImage(commitImage)
  );
endmodule

// File: tb/serial_unlock_ctrl_tb.sv
module serial_unlock_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycValid = 1'b0;
  logic cycWrite = 1'b0;
  logic dqIn = 1'b0;
  logic xferRstN = 1'b1;
  logic [63:0] rtcImage = '0;
  logic memInhibit, dqOut, commitStrobe;
  logic [63:0] commitImage;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_unlock_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycWrite(cycWrite),
    .dqIn(dqIn), .xferRstN(xferRstN), .rtcImage(rtcImage),
    .memInhibit(memInhibit), .dqOut(dqOut), .commitStrobe(commitStrobe),
    .commitImage(commitImage)
  );

  function automatic logic keyBit(int i);
    logic [7:0] b;
    case ((i / 8) % 4)
      0: b = 8'hC5;
      1: b = 8'h3A;
      2: b = 8'hA3;
      default: b = 8'h5C;
    endcase
    return b[i % 8];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doCyc(bit wr, bit b);
    @(negedge clk);
    cycValid = 1'b1; cycWrite = wr; dqIn = b;
    @(negedge clk);
    cycValid = 1'b0; cycWrite = 1'b0; dqIn = 1'b0;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock(bit withGaps);
    doCyc(1'b0, 1'b0);
    for (int i = 0; i < 64; i++) begin
      if (i == 63) chk(memInhibit == 1'b0, "R5", 64'(memInhibit), 64'd0);
      doCyc(1'b1, keyBit(i));
      if (withGaps && (i % 9 == 0)) gap(2);
    end
    chk(memInhibit == 1'b1, withGaps ? "R12" : "R2", 64'(memInhibit), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    logic [63:0] wdat;
    gap(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(memInhibit == 1'b0, "R1", 64'(memInhibit), 64'd0);
    chk(commitStrobe == 1'b0, "R1", 64'(commitStrobe), 64'd0);
    // R1: armed at bit 0 without a read
    for (int i = 0; i < 64; i++) doCyc(1'b1, keyBit(i));
    chk(memInhibit == 1'b1, "R1", 64'(memInhibit), 64'd1);
    for (int i = 0; i < 64; i++) doCyc(1'b0, 1'b0);
    chk(memInhibit == 1'b0, "R9", 64'(memInhibit), 64'd0);

    // R3/R4: a wrong bit at each position blocks unlock; a read re-arms
    for (int p = 0; p < 64; p++) begin
      doCyc(1'b0, 1'b0);
      for (int i = 0; i < 64; i++) doCyc(1'b1, (i == p) ? ~keyBit(i) : keyBit(i));
      doCyc(1'b1, keyBit(63));
      chk(memInhibit == 1'b0, "R3", 64'(memInhibit), 64'd0);
    end
    unlock(1'b0);
    chk(memInhibit == 1'b1, "R4", 64'(memInhibit), 64'd1);
    for (int i = 0; i < 64; i++) doCyc(1'b0, 1'b0);

    // R7: read window snapshot, R6 length
    rtcImage = 64'hA5C3_1E0F_0000_9B27;
    snap = rtcImage;
    unlock(1'b0);
    rtcImage = ~snap;
    for (int k = 0; k < 64; k++) begin
      if (k % 8 == 0 || k == 63)
        chk(dqOut == snap[k], "R7", 64'(dqOut), 64'(snap[k]));
      if (k == 63) chk(memInhibit == 1'b1, "R6", 64'(memInhibit), 64'd1);
      doCyc(1'b0, 1'b0);
    end
    chk(memInhibit == 1'b0, "R6", 64'(memInhibit), 64'd0);
    chk(commitStrobe == 1'b0, "R9", 64'(commitStrobe), 64'd0);

    // R8 and R12: full write window with idle gaps
    rtcImage = '0;
    wdat = 64'h0123_4567_89AB_CDEF;
    unlock(1'b1);
    for (int k = 0; k < 64; k++) begin
      doCyc(1'b1, wdat[k]);
      if (k == 20) gap(3);
    end
    chk(commitStrobe == 1'b1, "R8", 64'(commitStrobe), 64'd1);
    chk(commitImage == wdat, "R8", commitImage, wdat);
    chk(memInhibit == 1'b0, "R6", 64'(memInhibit), 64'd0);
    @(negedge clk);
    chk(commitStrobe == 1'b0, "R8", 64'(commitStrobe), 64'd0);

    // R9: 63 writes then a read
    unlock(1'b0);
    for (int k = 0; k < 63; k++) doCyc(1'b1, 1'b1);
    doCyc(1'b0, 1'b0);
    chk(commitStrobe == 1'b0, "R9", 64'(commitStrobe), 64'd0);
    chk(memInhibit == 1'b0, "R9", 64'(memInhibit), 64'd0);

    // R10: abort honoured
    rtcImage = '0;
    unlock(1'b0);
    for (int k = 0; k < 10; k++) doCyc(1'b1, 1'b1);
    @(negedge clk); xferRstN = 1'b0;
    @(negedge clk); xferRstN = 1'b1;
    chk(memInhibit == 1'b0, "R10", 64'(memInhibit), 64'd0);
    for (int k = 0; k < 54; k++) doCyc(1'b1, 1'b1);
    chk(commitStrobe == 1'b0, "R10", 64'(commitStrobe), 64'd0);

    // R11: abort ignored
    rtcImage = 64'd1 << 36;
    unlock(1'b0);
    for (int k = 0; k < 10; k++) doCyc(1'b1, 1'b0);
    @(negedge clk); xferRstN = 1'b0;
    @(negedge clk); xferRstN = 1'b1;
    chk(memInhibit == 1'b1, "R11", 64'(memInhibit), 64'd1);
    for (int k = 0; k < 54; k++) doCyc(1'b1, 1'b1);
    chk(commitStrobe == 1'b1, "R11", 64'(commitStrobe), 64'd1);
    chk(commitImage == {54'h3F_FFFF_FFFF_FFFF, 10'h000}, "R11", commitImage,
        {54'h3F_FFFF_FFFF_FFFF, 10'h000});

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule